// File: doc/BRIEF.md
# Register-Bank Data-Move Execution Unit

This block executes the control and data-move part of a small 8-bit microcontroller instruction set. Opcode and immediate bytes arrive over a valid/ready fetch handshake. The unit holds an accumulator and a status word whose bit 4 selects one of two banks of eight working registers. Both banks live inside a 64-byte internal data RAM. Indirect moves use the low six bits of working register 0 or 1 as a RAM address.

The unit also holds several flags and shows them on status outputs: interrupt enable, timer-pin clock-output enable, halt, and the program-memory bank flag. The bank flag does not act on the program counter straight away. It is copied into a program-counter bit 11 output only when the surrounding fetch logic pulses its jump/call strobe. With interrupts enabled, a low level on the interrupt pin raises an interrupt-request output.

Top module: `mv_exec_core`

## Requirements
- R1: After reset the following are all 0: accumulator, status word, program-bank flag, `pc11`, interrupt enable, clock-output enable, halt, illegal flag and all 64 RAM bytes. `op_ready` is 1 after reset.
- R2: Each control opcode sets or clears one flag. 0x05 sets interrupt enable and 0x15 clears it. 0x75 sets the clock-output enable. 0xE5 clears the program-bank flag and 0xF5 sets it. 0xC5 clears status bit 4 and 0xD5 sets it.
- R3: Working register r (0..7) maps to RAM address r when status bit 4 is 0, and to address 24+r when it is 1.
- R4: Opcodes 0x23 (accumulator), 0xB8+r (register r) and 0xB0/0xB1 (RAM at the address held in R0/R1) each take the next accepted byte as data. That byte is never decoded as an opcode. Each of these instructions uses two accepted bytes.
- R5: Opcode 0xF8+r copies register r into the accumulator. Opcode 0xA8+r copies the accumulator into register r. Opcode 0xC7 loads the accumulator with the status word, which has bit 4 equal to the bank bit and all other bits 0.
- R6: Opcode bit 0 picks R0 or R1 for the indirect opcodes 0xF0/0xF1 (RAM to accumulator) and 0xA0/0xA1 (accumulator to RAM). Only bits 5..0 of the chosen register form the RAM address; bits 7..6 are ignored.
- R7: `pc11` takes the program-bank flag value held before the clock edge at which `jmp_strobe` is high. At any other edge `pc11` keeps its value.
- R8: `irq_req` is 1 exactly when interrupt enable is 1 and `int_n` is 0.
- R9: Opcode 0x01 sets halt. From the next cycle until reset, `op_ready` is 0 and no byte changes any state.
- R10: An opcode outside this subset changes no state. It makes `illegal` high for exactly the one cycle after it is accepted.
- R11: A write to register r and an indirect write to the same RAM address leave the same RAM contents.
- R12: A cycle with `op_valid` low changes no state. This holds even between an immediate-form opcode and its data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Fetch byte valid |
| op_byte | input | 8 | Opcode or immediate byte |
| op_ready | output | 1 | Unit can accept a byte |
| int_n | input | 1 | Active-low interrupt pin |
| jmp_strobe | input | 1 | Jump/call taken; load pc11 |
| irq_req | output | 1 | Interrupt request |
| irq_en | output | 1 | Interrupt enable flag |
| t0_clk_en | output | 1 | Clock-output enable for the timer pin |
| halted | output | 1 | Halt flag |
| pbank | output | 1 | Pending program-memory bank flag |
| pc11 | output | 1 | Program-counter bit 11 |
| illegal | output | 1 | One-cycle unsupported-opcode pulse |
| acc_out | output | 8 | Accumulator |
| psw_out | output | 8 | Status word |

## Verification
Register moves are run in both banks, and the values are read back through indirect addressing with pointers of 0..7 and 24..31. This separates a correct bank offset from one that is missing or wrong. Indirect pointers with bits 7..6 set catch an address that is not masked to six bits. Immediate bytes chosen to look like control opcodes (0xF5, 0x01) show whether a data byte is wrongly decoded. Idle gaps between an opcode and its data byte, strobes that arrive before and after a bank-flag change, and bytes offered after halt each show whether state moves when it must hold.

// File: rtl/mv_pkg.sv
package mv_pkg;
   typedef enum logic [4:0] {
      K_BAD, K_IE_ON, K_IE_OFF, K_T0_ON, K_PB_CLR, K_PB_SET, K_BS_CLR, K_BS_SET,
      K_HALT, K_A_IMM, K_A_REG, K_A_IND, K_A_PSW, K_REG_IMM, K_REG_A, K_IND_A,
      K_IND_IMM
   } op_kind_e;

   localparam int BANK_BIT = 4;

   function automatic logic needs_imm(op_kind_e k);
      return (k == K_A_IMM) || (k == K_REG_IMM) || (k == K_IND_IMM);
   endfunction

   function automatic logic is_indirect(op_kind_e k);
      return (k == K_A_IND) || (k == K_IND_A) || (k == K_IND_IMM);
   endfunction
endpackage

// File: rtl/mv_decode.sv
module mv_decode
   import mv_pkg::*;
(
   input  logic [7:0] op,
   output op_kind_e   kind
);
   always_comb begin
      casez (op)
         8'h05:        kind = K_IE_ON;
         8'h15:        kind = K_IE_OFF;
         8'h75:        kind = K_T0_ON;
         8'hE5:        kind = K_PB_CLR;
         8'hF5:        kind = K_PB_SET;
         8'hC5:        kind = K_BS_CLR;
         8'hD5:        kind = K_BS_SET;
         8'h01:        kind = K_HALT;
         8'h23:        kind = K_A_IMM;
         8'hC7:        kind = K_A_PSW;
         8'b1111_1???: kind = K_A_REG;
         8'b1111_000?: kind = K_A_IND;
         8'b1011_1???: kind = K_REG_IMM;
         8'b1011_000?: kind = K_IND_IMM;
         8'b1010_1???: kind = K_REG_A;
         8'b1010_000?: kind = K_IND_A;
         default:      kind = K_BAD;
      endcase
   end
endmodule

// File: rtl/mv_dram.sv
module mv_dram #(
   parameter int DATA_W    = 8,
   parameter int RAM_AW    = 6,
   parameter bit CLEAR_RAM = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RAM_AW-1:0] ra0,
   output logic [DATA_W-1:0] rd0,
   input  logic [RAM_AW-1:0] ra1,
   output logic [DATA_W-1:0] rd1,
   input  logic              we,
   input  logic [RAM_AW-1:0] wa,
   input  logic [DATA_W-1:0] wd
);
   localparam int DEPTH = 1 << RAM_AW;

   logic [DATA_W-1:0] mem [DEPTH];

   generate
      if (CLEAR_RAM) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we) begin
               mem[wa] <= wd;
            end
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (we) mem[wa] <= wd;
         end
      end
   endgenerate

   assign rd0 = mem[ra0];
   assign rd1 = mem[ra1];

   // R11: whichever path supplied the address, the written byte lands there
   p_write_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> mem[$past(wa)] == $past(wd));
endmodule

// File: rtl/mv_exec_core.sv
module mv_exec_core
   import mv_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int RAM_AW     = 6,
   parameter int BANK1_BASE = 24,
   parameter bit CLEAR_RAM  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [7:0]        op_byte,
   output logic              op_ready,
   input  logic              int_n,
   input  logic              jmp_strobe,
   output logic              irq_req,
   output logic              irq_en,
   output logic              t0_clk_en,
   output logic              halted,
   output logic              pbank,
   output logic              pc11,
   output logic              illegal,
   output logic [DATA_W-1:0] acc_out,
   output logic [DATA_W-1:0] psw_out
);
   localparam int DEPTH    = 1 << RAM_AW;
   localparam int REG_CNT  = 8;

   generate
      if (DATA_W != 8) begin : g_bad_w
         $error("mv_exec_core: opcodes are bytes, DATA_W must be 8");
      end
      if (RAM_AW > DATA_W) begin : g_bad_aw
         $error("mv_exec_core: pointer field wider than a register");
      end
      if (BANK1_BASE + REG_CNT > DEPTH || BANK1_BASE < REG_CNT) begin : g_bad_base
         $error("mv_exec_core: upper bank must fit in RAM above the lower bank");
      end
   endgenerate

   logic              pend_q, ie_q, t0_q, halt_q, pb_q, pc11_q, ill_q, bs_q;
   logic [7:0]        held_q;
   logic [DATA_W-1:0] acc_q, psw;
   logic [7:0]        cur_op;
   op_kind_e          kind;
   logic              accept, take_imm, fire;
   logic [2:0]        rsel;
   logic [RAM_AW-1:0] reg_addr, ptr;
   logic [DATA_W-1:0] rd0, rd1, wd;
   logic [RAM_AW-1:0] wa;
   logic              we;

   assign accept   = op_valid & ~halt_q;
   assign cur_op   = pend_q ? held_q : op_byte;
   assign take_imm = needs_imm(kind);
   assign fire     = accept & (pend_q | ~take_imm);

   mv_decode u_dec (.op(cur_op), .kind(kind));

   always_comb begin
      rsel     = is_indirect(kind) ? {2'b00, cur_op[0]} : cur_op[2:0];
      reg_addr = bs_q ? RAM_AW'(BANK1_BASE) + RAM_AW'(rsel) : RAM_AW'(rsel);
      ptr      = rd0[RAM_AW-1:0];
      psw      = '0;
      psw[BANK_BIT] = bs_q;
      we = fire & ((kind == K_REG_IMM) | (kind == K_REG_A) |
                   (kind == K_IND_A)   | (kind == K_IND_IMM));
      wa = ((kind == K_IND_A) | (kind == K_IND_IMM)) ? ptr : reg_addr;
      wd = ((kind == K_REG_A) | (kind == K_IND_A)) ? acc_q : op_byte;
   end

   mv_dram #(.DATA_W(DATA_W), .RAM_AW(RAM_AW), .CLEAR_RAM(CLEAR_RAM)) u_ram (
      .clk(clk), .rst_n(rst_n),
      .ra0(reg_addr), .rd0(rd0),
      .ra1(ptr),      .rd1(rd1),
      .we(we), .wa(wa), .wd(wd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;  held_q <= '0;   acc_q <= '0;   bs_q  <= 1'b0;
         ie_q   <= 1'b0;  t0_q   <= 1'b0; halt_q <= 1'b0; pb_q <= 1'b0;
         pc11_q <= 1'b0;  ill_q  <= 1'b0;
      end else begin
         ill_q <= 1'b0;
         if (jmp_strobe) pc11_q <= pb_q;
         if (accept & ~pend_q & take_imm) begin
            pend_q <= 1'b1;
            held_q <= op_byte;
         end else if (fire) begin
            pend_q <= 1'b0;
         end
         if (fire) begin
            case (kind)
               K_BAD:    ill_q  <= 1'b1;
               K_IE_ON:  ie_q   <= 1'b1;
               K_IE_OFF: ie_q   <= 1'b0;
               K_T0_ON:  t0_q   <= 1'b1;
               K_PB_CLR: pb_q   <= 1'b0;
               K_PB_SET: pb_q   <= 1'b1;
               K_BS_CLR: bs_q   <= 1'b0;
               K_BS_SET: bs_q   <= 1'b1;
               K_HALT:   halt_q <= 1'b1;
               K_A_IMM:  acc_q  <= op_byte;
               K_A_REG:  acc_q  <= rd0;
               K_A_IND:  acc_q  <= rd1;
               K_A_PSW:  acc_q  <= psw;
               default:  ;
            endcase
         end
      end
   end

   assign op_ready  = ~halt_q;
   assign irq_req   = ie_q & ~int_n;
   assign irq_en    = ie_q;
   assign t0_clk_en = t0_q;
   assign halted    = halt_q;
   assign pbank     = pb_q;
   assign pc11      = pc11_q;
   assign illegal   = ill_q;
   assign acc_out   = acc_q;
   assign psw_out   = psw;

   // R9: halt holds until reset and freezes architectural state
   p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      halt_q |=> halt_q);
   p_halt_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      halt_q |=> $stable(acc_q) && $stable(bs_q) && $stable(pb_q) && $stable(ie_q));
   // R7: pc11 moves only on the strobe, and then to the pending bank flag
   p_pc11_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !jmp_strobe |=> $stable(pc11_q));
   p_pc11_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      jmp_strobe |=> pc11_q == $past(pb_q));
   // R8: no request while interrupts are masked
   p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ie_q |-> !irq_req);
   // R10: illegal pulse only follows an executed byte
   p_ill_after_fire_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ill_q |-> $past(fire));
   // R12: idle cycles leave state alone
   p_idle_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(acc_q) && $stable(bs_q) && $stable(pend_q));
endmodule

// File: tb/mv_exec_core_tb.sv
`timescale 1ns/1ps
module mv_exec_core_tb;
   logic clk = 1'b0, rst_n = 1'b0;
   logic op_valid = 1'b0, int_n = 1'b1, jmp_strobe = 1'b0;
   logic [7:0] op_byte = 8'h00;
   logic op_ready, irq_req, irq_en, t0_clk_en, halted, pbank, pc11, illegal;
   logic [7:0] acc_out, psw_out;

   always #2.5 clk = ~clk;

   mv_exec_core u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_byte(op_byte),
      .op_ready(op_ready), .int_n(int_n), .jmp_strobe(jmp_strobe),
      .irq_req(irq_req), .irq_en(irq_en), .t0_clk_en(t0_clk_en),
      .halted(halted), .pbank(pbank), .pc11(pc11), .illegal(illegal),
      .acc_out(acc_out), .psw_out(psw_out)
   );

   // behavioural reference
   int m_mem [64];
   int m_acc, m_held;
   bit m_bs, m_ie, m_t0, m_halt, m_pb, m_pc11, m_ill, m_pend;
   int total = 0, bad = 0, cyc = 0;
   string cur_req = "R1";

   function automatic int raddr(int r);
      return (m_bs ? 24 : 0) + r;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_acc = 0; m_held = 0; m_bs = 0; m_ie = 0; m_t0 = 0; m_halt = 0;
         m_pb = 0; m_pc11 = 0; m_ill = 0; m_pend = 0;
         for (int i = 0; i < 64; i++) m_mem[i] = 0;
      end else begin
         m_ill = 0;
         if (jmp_strobe) m_pc11 = m_pb;
         if (op_valid && !m_halt) begin
            int b;
            b = int'(op_byte);
            if (m_pend) begin
               m_pend = 0;
               if (m_held == 'h23) m_acc = b;
               else if (m_held >= 'hB8) m_mem[raddr(m_held % 8)] = b;
               else m_mem[m_mem[raddr(m_held % 2)] % 64] = b;
            end else if (b == 'h05) m_ie = 1;
            else if (b == 'h15) m_ie = 0;
            else if (b == 'h75) m_t0 = 1;
            else if (b == 'hE5) m_pb = 0;
            else if (b == 'hF5) m_pb = 1;
            else if (b == 'hC5) m_bs = 0;
            else if (b == 'hD5) m_bs = 1;
            else if (b == 'h01) m_halt = 1;
            else if (b == 'h23 || (b >= 'hB8 && b <= 'hBF) || b == 'hB0 || b == 'hB1) begin
               m_pend = 1; m_held = b;
            end
            else if (b >= 'hF8) m_acc = m_mem[raddr(b % 8)];
            else if (b == 'hF0 || b == 'hF1) m_acc = m_mem[m_mem[raddr(b % 2)] % 64];
            else if (b == 'hC7) m_acc = m_bs ? 16 : 0;
            else if (b >= 'hA8 && b <= 'hAF) m_mem[raddr(b % 8)] = m_acc;
            else if (b == 'hA0 || b == 'hA1) m_mem[m_mem[raddr(b % 2)] % 64] = m_acc;
            else m_ill = 1;
         end
      end
   end

   task automatic chk(string what, int got, int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s %s: got %0h expected %0h", cur_req, what, got, exp);
      end
   endtask

   task automatic compare_all();
      if (!rst_n) return;
      chk("acc", int'(acc_out), m_acc);
      chk("psw", int'(psw_out), m_bs ? 16 : 0);
      chk("irq_en", int'(irq_en), int'(m_ie));
      chk("t0_clk_en", int'(t0_clk_en), int'(m_t0));
      chk("halted", int'(halted), int'(m_halt));
      chk("op_ready", int'(op_ready), int'(!m_halt));
      chk("pbank", int'(pbank), int'(m_pb));
      chk("pc11", int'(pc11), int'(m_pc11));
      chk("illegal", int'(illegal), int'(m_ill));
      chk("irq_req", int'(irq_req), int'(m_ie && !int_n));
   endtask

   // drive at negedge, let one edge pass, compare at the following negedge
   task automatic step(bit v, logic [7:0] b, bit inn = 1'b1, bit js = 1'b0);
      op_valid = v; op_byte = b; int_n = inn; jmp_strobe = js;
      @(posedge clk);
      @(negedge clk);
      compare_all();
   endtask

   task automatic op(logic [7:0] b);
      step(1'b1, b);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      op_valid = 1'b0; jmp_strobe = 1'b0; int_n = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      compare_all();
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         total++; bad++;
         $display("FAIL watchdog: got %0d cycles expected under 50000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      cur_req = "R1"; do_reset();
      step(1'b0, 8'h00);

      cur_req = "R2";
      op(8'h05); op(8'h75); op(8'hF5); op(8'hD5);
      op(8'hC5); op(8'hE5); op(8'h15); op(8'h05);

      cur_req = "R8";
      step(1'b0, 8'h00, 1'b0); step(1'b0, 8'h00, 1'b1);
      op(8'h15); step(1'b0, 8'h00, 1'b0); op(8'h05);

      cur_req = "R7";
      op(8'hF5); step(1'b0, 8'h00, 1'b1, 1'b0);
      step(1'b1, 8'hE5, 1'b1, 1'b1);   // strobe sees the old flag (1)
      step(1'b0, 8'h00, 1'b1, 1'b0);
      step(1'b0, 8'h00, 1'b1, 1'b1);   // now loads 0

      cur_req = "R4";
      op(8'h23); op(8'hF5);            // data that looks like an opcode
      for (int r = 0; r < 8; r++) begin op(8'hB8 + 8'(r)); op(8'h10 + 8'(r)); end
      op(8'h23); op(8'h01);

      cur_req = "R5";
      for (int r = 0; r < 8; r++) op(8'hF8 + 8'(r));
      op(8'h23); op(8'h3C); op(8'hAD); op(8'h23); op(8'h00); op(8'hFD);
      op(8'hC7); op(8'hD5); op(8'hC7);

      cur_req = "R3";
      for (int r = 0; r < 8; r++) begin op(8'hB8 + 8'(r)); op(8'h60 + 8'(r)); end
      op(8'hC5);
      for (int r = 0; r < 8; r++) begin op(8'hB8); op(8'(24 + r)); op(8'hF0); end
      op(8'hB9); op(8'h05); op(8'hF1);

      cur_req = "R6";
      op(8'hB9); op(8'hC5); op(8'h23); op(8'h9E); op(8'hA1); op(8'hFD);
      op(8'hB8); op(8'h42); op(8'hB0); op(8'h7B); op(8'hFA); op(8'hF0);
      op(8'hB8); op(8'hFF); op(8'hF0);

      cur_req = "R11";
      op(8'h23); op(8'h11); op(8'hAB); op(8'hB8); op(8'h03);
      op(8'h23); op(8'h22); op(8'hA0); op(8'hFB);
      op(8'hB0); op(8'h33); op(8'hFB); op(8'hBB); op(8'h44); op(8'hF0);

      cur_req = "R12";
      step(1'b0, 8'h15); step(1'b0, 8'hD5);
      op(8'h23); step(1'b0, 8'hC5); step(1'b0, 8'h05); op(8'h6A);
      op(8'hBC); step(1'b0, 8'h00); op(8'h57); op(8'hFC);

      cur_req = "R10";
      op(8'h00); op(8'h02); op(8'h02); op(8'h3F); step(1'b0, 8'h00); op(8'hC7);

      cur_req = "R9";
      op(8'h01);
      op(8'h23); op(8'hFF); op(8'hF5); op(8'hD5); op(8'h15);
      step(1'b0, 8'h00, 1'b0);

      cur_req = "R1"; do_reset();
      op(8'hF8); op(8'hF0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule